// File: doc/BRIEF.md
# Glitch-Free Two-Clock Switch

This block picks one of two free-running clocks, a primary and a secondary, and drives the chosen clock to a set of identical outputs. Changing the selection never shortens a high or low phase on the outputs. The block first turns off the path that is currently active, in step with that path's own clock, and holds the outputs low. It then turns on the other path in step with the new clock. Each path has a short synchronizer followed by a gate flop that changes only while its clock is low. The path that is switching in is armed only after the path that is switching out has confirmed that it is off.

If the clock being left has stopped, the handoff cannot complete on its own. A force input clears the old path's enable directly, without waiting for that clock, so the new clock can take over. An output gate with no clock in its path can park the outputs at a chosen level. A power-down input holds the outputs at a fixed level. Power-down takes priority over the output gate.

Top module: `gl_clk_switch`

## Requirements
- R1: With `src_sel` = 0 the outputs follow `clk_pri`, and with `src_sel` = 1 they follow `clk_sec`, once the handoff is complete (`out_en` = 1, `pwr_dn` = 0).
- R2: After `src_sel` changes, the outputs are low no later than the third rising edge of the previously selected clock. They stay low until the new path is on.
- R3: After a selection change, the first rising output edge comes from the new clock. It arrives no later than three periods of the old clock plus four periods of the new clock after the change.
- R4: No output high or low phase is shorter than half the period of the faster input clock. The two path enables are never on together.
- R5: If the old clock has stopped and `force_sw` = 0, the switch stalls with the outputs low. Raising `force_sw` lets the outputs follow the new clock within four of its cycles.
- R6: While `out_en` = 0 the outputs drive `park_lvl` at once, with no clock edge needed.
- R7: While `pwr_dn` = 1 the outputs are held at `PD_LEVEL` (default 0) whatever the value of `out_en` or `park_lvl`.
- R8: All `NUM_OUT` outputs carry the same value at all times.
- R9: While `rst_n` = 0 both paths are off, so the outputs are low when `out_en` = 1. After release, the selected clock appears within four of its cycles, and a high `force_sw` during reset does not change this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary input clock, selected when `src_sel` = 0 |
| clk_sec | input | 1 | Secondary input clock, selected when `src_sel` = 1 |
| rst_n | input | 1 | Asynchronous active-low reset of both paths |
| src_sel | input | 1 | Source select: 0 primary, 1 secondary |
| force_sw | input | 1 | Completes a switch away from a dead clock |
| out_en | input | 1 | Output gate, 1 forwards the clock, 0 parks the outputs |
| park_lvl | input | 1 | Level driven while `out_en` = 0 |
| pwr_dn | input | 1 | Power-down, holds the outputs at `PD_LEVEL` |
| clk_out | output | NUM_OUT | Identical switched clock outputs |

## Verification
The bench builds the block with `NUM_OUT` = 2 and `SYNC_STAGES` = 2, the shortest chain allowed. That chain length is the setting for which the three-cycle handoff windows are tight, so the latency limits of R2 and R3 are checked at their strictest. Two outputs make the equality check of R8 meaningful. The bench runs the primary clock at 8 ns and the secondary at 12 ns. This covers a handoff from the faster clock to the slower one and back again, and the runt check uses half of the faster period. With `PD_LEVEL` left at 0, power-down and park-high give opposite output levels, so the priority between them in R7 can be observed.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

   localparam int unsigned LANES = 2;

   typedef enum logic {
      SRC_PRI = 1'b0,
      SRC_SEC = 1'b1
   } src_e;

   typedef struct packed {
      logic pwr_dn;
      logic drive;
      logic park;
   } gate_ctl_t;

   // power-down wins over the park gate, park gate wins over the clock
   function automatic logic gate_bit(gate_ctl_t c, logic mixed, logic pd_lvl);
      logic r;
      if (c.pwr_dn)
         r = pd_lvl;
      else if (!c.drive)
         r = c.park;
      else
         r = mixed;
      return r;
   endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clksw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
module clksw_lane #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic kill,
   output logic en,
   output logic gclk
);
   logic kill_n;
   logic want_s;

   // a forced kill clears the lane without waiting on its clock
   assign kill_n = rst_n & ~kill;

   clksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr_n (kill_n),
      .d     (want),
      .q     (want_s)
   );

   // gate changes on the falling edge only, while clk is low
   always_ff @(negedge clk or negedge kill_n) begin
      if (!kill_n)
         en <= 1'b0;
      else
         en <= want_s;
   end

   assign gclk = clk & en;
endmodule

// File: rtl/clksw_outgate.sv
`timescale 1ns/1ps
module clksw_outgate
   import clksw_pkg::*;
#(
   parameter int unsigned NUM_OUT  = 2,
   parameter bit          PD_LEVEL = 1'b0
) (
   input  logic [LANES-1:0]   gclk,
   input  gate_ctl_t          ctl,
   output logic [NUM_OUT-1:0] clk_out
);
   logic mixed;

   assign mixed = |gclk;

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      assign clk_out[k] = gate_bit(ctl, mixed, PD_LEVEL);
   end
endmodule

// File: rtl/gl_clk_switch.sv
`timescale 1ns/1ps
module gl_clk_switch
   import clksw_pkg::*;
#(
   parameter int unsigned NUM_OUT     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PD_LEVEL    = 1'b0
) (
   input  logic               clk_pri,
   input  logic               clk_sec,
   input  logic               rst_n,
   input  logic               src_sel,
   input  logic               force_sw,
   input  logic               out_en,
   input  logic               park_lvl,
   input  logic               pwr_dn,
   output logic [NUM_OUT-1:0] clk_out
);
   generate
      if (NUM_OUT < 1) begin : g_bad_out
         $error("gl_clk_switch: NUM_OUT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gl_clk_switch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LANES-1:0] lane_clk;
   logic [LANES-1:0] lane_want;
   logic [LANES-1:0] lane_kill;
   logic [LANES-1:0] lane_en;
   logic [LANES-1:0] lane_gclk;
   gate_ctl_t        ctl;

   assign lane_clk = {clk_sec, clk_pri};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic MY_SEL = (i == 0) ? SRC_PRI : SRC_SEC;
      localparam int   OTHER  = LANES - 1 - i;

      // arm only once the other lane has confirmed it is off
      assign lane_want[i] = (src_sel == MY_SEL) & ~lane_en[OTHER];
      // forced handoff: drop this lane at once when it is deselected
      assign lane_kill[i] = force_sw & (src_sel != MY_SEL);

      clksw_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk   (lane_clk[i]),
         .rst_n (rst_n),
         .want  (lane_want[i]),
         .kill  (lane_kill[i]),
         .en    (lane_en[i]),
         .gclk  (lane_gclk[i])
      );
   end

   assign ctl.pwr_dn = pwr_dn;
   assign ctl.drive  = out_en;
   assign ctl.park   = park_lvl;

   clksw_outgate #(.NUM_OUT(NUM_OUT), .PD_LEVEL(PD_LEVEL)) u_gate (
      .gclk    (lane_gclk),
      .ctl     (ctl),
      .clk_out (clk_out)
   );
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk #(
   parameter int unsigned NUM_OUT  = 2,
   parameter bit          PD_LEVEL = 1'b0
) (
   input logic               clk_pri,
   input logic               clk_sec,
   input logic               rst_n,
   input logic               src_sel,
   input logic               force_sw,
   input logic               out_en,
   input logic               park_lvl,
   input logic               pwr_dn,
   input logic [NUM_OUT-1:0] clk_out,
   input logic               en_pri,
   input logic               en_sec
);
   logic [2:0] pri_hold;
   logic [2:0] sec_hold;

   // rising edges of the old clock seen while its lane is deselected but on
   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n)
         pri_hold <= '0;
      else if (src_sel && en_pri && !force_sw)
         pri_hold <= (pri_hold == 3'd7) ? pri_hold : pri_hold + 3'd1;
      else
         pri_hold <= '0;
   end

   always_ff @(posedge clk_sec or negedge rst_n) begin
      if (!rst_n)
         sec_hold <= '0;
      else if (!src_sel && en_sec && !force_sw)
         sec_hold <= (sec_hold == 3'd7) ? sec_hold : sec_hold + 3'd1;
      else
         sec_hold <= '0;
   end

   assert_pri_off_R2: assert property (@(posedge clk_pri) disable iff (!rst_n)
      pri_hold <= 3'd3);

   assert_sec_off_R2: assert property (@(posedge clk_sec) disable iff (!rst_n)
      sec_hold <= 3'd3);

   assert_arm_after_off_R4: assert property (@(negedge clk_pri) disable iff (!rst_n)
      $rose(en_pri) |-> !en_sec);

   assert_force_kill_R5: assert property (@(posedge clk_sec) disable iff (!rst_n)
      (force_sw && src_sel) |-> !en_pri);

   always_comb begin
      if (rst_n) begin
         assert_one_path_R4: assert (!(en_pri && en_sec));
      end
      if (rst_n && !pwr_dn && !out_en) begin
         assert_park_R6: assert (clk_out == {NUM_OUT{park_lvl}});
      end
      if (rst_n && pwr_dn) begin
         assert_pd_hold_R7: assert (clk_out == {NUM_OUT{PD_LEVEL}});
      end
   end
endmodule

bind gl_clk_switch clksw_chk #(.NUM_OUT(NUM_OUT), .PD_LEVEL(PD_LEVEL)) u_chk (
   .clk_pri  (clk_pri),
   .clk_sec  (clk_sec),
   .rst_n    (rst_n),
   .src_sel  (src_sel),
   .force_sw (force_sw),
   .out_en   (out_en),
   .park_lvl (park_lvl),
   .pwr_dn   (pwr_dn),
   .clk_out  (clk_out),
   .en_pri   (lane_en[0]),
   .en_sec   (lane_en[1])
);

// File: tb/sim_gl_clk_switch.sv
`timescale 1ns/1ps
module sim_gl_clk_switch;
   localparam int  NO   = 2;
   localparam real PA   = 8.0;
   localparam real PB   = 12.0;
   // {out_en, park_lvl, pwr_dn, mode}; mode 0 low, 1 high, 2 follow clock
   localparam logic [4:0] GATE_TBL [6] = '{5'b10010, 5'b01001, 5'b00000,
                                           5'b11100, 5'b01100, 5'b11010};

   logic clk_a = 1'b0, clk_b = 1'b0;
   bit   run_a = 1'b1, run_b = 1'b1;
   logic rst_n = 1'b0, sel = 1'b0, frc = 1'b0;
   logic oen = 1'b1, park = 1'b0, pd = 1'b0;
   logic [NO-1:0] clk_out;

   int  checks = 0, fails = 0, runts = 0, mism = 0;
   bit  mon_on = 1'b0, have_last = 1'b0, done = 1'b0;
   real last_t = 0.0, t0 = 0.0;

   always #4 if (run_a) clk_a = ~clk_a;
   always #6 if (run_b) clk_b = ~clk_b;

   gl_clk_switch #(.NUM_OUT(NO), .SYNC_STAGES(2), .PD_LEVEL(1'b0)) u0 (
      .clk_pri(clk_a), .clk_sec(clk_b), .rst_n(rst_n), .src_sel(sel),
      .force_sw(frc), .out_en(oen), .park_lvl(park), .pwr_dn(pd),
      .clk_out(clk_out));

   // R4: runt monitor on output phases
   always @(clk_out[0]) begin
      if (mon_on) begin
         if (have_last && ($realtime - last_t) < (PA / 2.0 - 0.001)) runts++;
         have_last = 1'b1;
         last_t = $realtime;
      end else begin
         have_last = 1'b0;
      end
   end

   // R8: outputs must agree
   always @(clk_out) begin
      #0.1;
      if (clk_out[0] !== clk_out[1]) mism++;
   end

   task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_le(input string req, input real act, input real lim);
      checks++;
      if (act > lim) begin
         fails++;
         $display("FAIL %s: actual %0.2f ns expected <= %0.2f ns", req, act, lim);
      end
   endtask

   task automatic follow_a(input string req);
      @(posedge clk_a); #1; chk(req, clk_out, 2'b11);
      @(negedge clk_a); #1; chk(req, clk_out, 2'b00);
   endtask

   task automatic follow_b(input string req);
      @(posedge clk_b); #1; chk(req, clk_out, 2'b11);
      @(negedge clk_b); #1; chk(req, clk_out, 2'b00);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk_a);
      #1; chk("R9 reset low", clk_out, 2'b00);
      @(posedge clk_b); #1; chk("R9 reset low", clk_out, 2'b00);
      @(posedge clk_a); #1; rst_n = 1'b1;
      repeat (4) @(posedge clk_a);
      follow_a("R9 post-reset R1");

      // R6 R7 R1: gate table walk
      for (int r = 0; r < 6; r++) begin
         logic [4:0]    v;
         logic [NO-1:0] hi_e, lo_e;
         string         tag;
         v = GATE_TBL[r];
         tag = v[2] ? "R7 pd" : (!v[4] ? "R6 park" : "R1 drive");
         hi_e = (v[1:0] == 2'd0) ? 2'b00 : 2'b11;
         lo_e = (v[1:0] == 2'd1) ? 2'b11 : 2'b00;
         @(posedge clk_a); #1;
         oen = v[4]; park = v[3]; pd = v[2];
         #1; chk(tag, clk_out, hi_e);
         @(negedge clk_a); #1; chk(tag, clk_out, lo_e);
      end
      oen = 1'b1; park = 1'b0; pd = 1'b0;

      // R2 R3 R1: primary to secondary
      @(negedge clk_a); mon_on = 1'b1;
      @(posedge clk_a); #1; sel = 1'b1; t0 = $realtime;
      repeat (3) @(posedge clk_a);
      #1; chk("R2 old off a", clk_out, 2'b00);
      @(posedge clk_out[0]);
      chk_le("R3 latency a->b", $realtime - t0, 3.0 * PA + 4.0 * PB);
      chk("R3 source b", {NO{clk_b}}, 2'b11);
      follow_b("R1 sel=1");
      follow_b("R1 sel=1");

      // R2 R3 R1: secondary to primary
      @(posedge clk_b); #1; sel = 1'b0; t0 = $realtime;
      repeat (3) @(posedge clk_b);
      #1; chk("R2 old off b", clk_out, 2'b00);
      @(posedge clk_out[0]);
      chk_le("R3 latency b->a", $realtime - t0, 3.0 * PB + 4.0 * PA);
      chk("R3 source a", {NO{clk_a}}, 2'b11);
      follow_a("R1 sel=0");
      @(negedge clk_a); mon_on = 1'b0;
      chk("R4 runt count", 2'(runts), 2'(0));
      chk("R8 output mismatch", 2'(mism), 2'(0));

      // R5: dead primary clock
      @(negedge clk_a); run_a = 1'b0;
      #1; sel = 1'b1;
      repeat (10) @(posedge clk_b);
      #1; chk("R5 stall high phase", clk_out, 2'b00);
      @(negedge clk_b); #1; chk("R5 stall low phase", clk_out, 2'b00);
      @(posedge clk_b); #1; frc = 1'b1;
      repeat (4) @(posedge clk_b);
      #1; chk("R5 forced switch", clk_out, 2'b11);
      @(negedge clk_b); #1; chk("R5 forced switch", clk_out, 2'b00);
      frc = 1'b0; run_a = 1'b1;
      follow_b("R5 after force release");

      // R9: force held high through reset has no effect
      @(posedge clk_a); #1; rst_n = 1'b0; frc = 1'b1; sel = 1'b0;
      repeat (3) @(posedge clk_a);
      #1; chk("R9 reset with force", clk_out, 2'b00);
      rst_n = 1'b1;
      repeat (4) @(posedge clk_a);
      follow_a("R9 force during reset");
      frc = 1'b0;
      follow_a("R9 force released");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule